// File: doc/BRIEF.md
# EDID Read Controller with Register Interface

This block lets a host fetch the identification bytes of an attached monitor through four 32-bit memory-mapped registers. The host programs the registers as it would program a display I2C master: it writes a port-select register, then a command register, then polls status and reads the data register. The identification bytes come from an internal 128-byte memory, filled beforehand through a separate load port. No I2C pins exist. The controller keeps a read pointer, a selected-target flag, an availability flag and a bus phase, and it derives the register results from these.

Every data-register read returns up to four bytes packed little-endian, and the pointer moves past each byte it fetches. When a transfer ends, the controller drops into the idle or wait phase, depending on how the command said the transfer ends. The status register sets an in-use flag whenever it is read, and a write of one clears that flag. A clear-interrupt bit in the command register clears the interrupt flag when the host sets it, and resets the controller when the host clears it again.

Top module: `edid_read_ctrl`

## Requirements
- R1: After reset, the status register reads 0, `bus_phase` is 0 (idle), the select register reads 0, and `rsp_valid` is low.
- R2: A select write stores the value and reinitialises the read state. With pin field [2:0] nonzero, status becomes ready (bit 0) and wait (bit 2) with active (bit 1) clear, and the phase becomes idle (0). Error (bit 3) is cleared when `mon_present[pin]` is 1 and set otherwise. With pin 0, status and phase are unchanged.
- R3: A status read (address 2) returns the current value and then sets in-use (bit 5). A status write with bit 5 at 1 clears in-use. No status write changes any other bit.
- R4: A command write (address 1) selects the target only when bits [7:1] equal 0x50. With any other address, later fetches return zero bytes.
- R5: A data read (address 3) with command bit 0 set computes remaining = count[24:16] − pointer. When remaining > 0, it replaces the low min(remaining,4) bytes of the data register (byte i at bits 8i+7:8i, taken from pointer+i), keeps the upper bytes, returns the result and advances the pointer by each byte actually fetched.
- R6: When a fetching read sees remaining ≤ 4, the read state is reinitialised. The phase becomes idle for cycle codes 5 and 7, and wait (2) for the other codes. A later data read then returns the stored value unchanged.
- R7: A command write with bit 26 set loads the pointer from bits [15:8].
- R8: Cycle code 4 (stop), in bits [27:25], acts only if the previously stored code was nonzero. It then reinitialises the read state, sets the phase to idle and clears active.
- R9: Odd cycle codes (1, 3, 5, 7) set the phase to data (1) and set active. Codes 0 and 2 leave the phase and active unchanged.
- R10: A command write with bit 31 at 1, when the stored bit 31 is 0, clears interrupt (bit 4) and sets ready. A command write with bit 31 at 0, when the stored bit 31 is 1, clears only stored bit 31. It sets status to ready alone, plus error if no monitor was available, and the phase goes idle.
- R11: Bit 30 of a written command is always stored as 0.
- R12: A fetched byte is 0, and the pointer does not move, when no monitor is available or when the byte position is at or beyond 128.
- R13: A data read returns the stored data unchanged in two cases: when stored command bit 0 is 0, or when remaining ≤ 0.
- R14: `rsp_valid` is high in exactly the cycle after an accepted read, and `rsp_rdata` holds that read's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | 0 select, 1 command, 2 status, 3 data |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read result valid |
| rsp_rdata | output | 32 | Read result |
| mon_present | input | 8 | Monitor-present flag per pin value |
| ld_en | input | 1 | Identification memory load strobe |
| ld_addr | input | 7 | Load address |
| ld_data | input | 8 | Load byte |
| bus_phase | output | 2 | 0 idle, 1 data, 2 wait |

## Verification
Several internal faults show up at the ports on the next data-register read: a pointer off by one, a lost target-selected flag or a stale count. Each appears as a wrong byte in a known lane, or as an upper byte that was not kept. A wrong phase decision at the end of a transfer appears on `bus_phase` one cycle after the last fetching read. The status flags appear one read later, and the bench first clears in-use with a write so that the read-to-set side effect does not hide them.

// File: rtl/edid_read_ctrl.sv
module edid_read_ctrl #(
  parameter int EDID_BYTES = 128,
  parameter logic [6:0] TARGET = 7'h50,
  localparam int MA = $clog2(EDID_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic [7:0]  mon_present,
  input  logic        ld_en,
  input  logic [MA-1:0] ld_addr,
  input  logic [7:0]  ld_data,
  output logic [1:0]  bus_phase
);
  localparam int LANES = 4;
  localparam int ST_RDY = 0, ST_ACT = 1, ST_WAIT = 2, ST_ERR = 3, ST_INT = 4, ST_USE = 5;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_DATA = 2'd1, PH_WAIT = 2'd2;

  logic [7:0]  mem [EDID_BYTES];
  logic [31:0] sel_q, cmd_q, data_q;
  logic [5:0]  stat_q;
  logic [1:0]  phase_q;
  logic [7:0]  ptr_q;
  logic [8:0]  total_q;
  logic [2:0]  cyc_q;
  logic        tgt_sel, avail;

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  logic signed [9:0] remaining;
  logic [2:0] rd_cnt;
  logic [LANES-1:0] lane_take, lane_ok;
  logic [7:0] lane_byte [LANES];
  logic [31:0] data_next;

  assign remaining = $signed({1'b0, total_q}) - $signed({2'b00, ptr_q});
  assign rd_cnt = (remaining <= 10'sd0) ? 3'd0 :
                  (remaining >= 10'sd4) ? 3'd4 : remaining[2:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] pos;
    assign pos = {1'b0, ptr_q} + 9'(i);
    assign lane_take[i] = 3'(i) < rd_cnt;
    assign lane_ok[i] = lane_take[i] && tgt_sel && avail && (pos < 9'(EDID_BYTES));
    assign lane_byte[i] = lane_ok[i] ? mem[pos[MA-1:0]] : 8'h00;
    assign data_next[8*i +: 8] = lane_take[i] ? lane_byte[i] : data_q[8*i +: 8];
  end

  wire rd_req   = req_valid && !req_write;
  wire wr_req   = req_valid && req_write;
  wire fetching = rd_req && req_addr == 2'd3 && cmd_q[0] && remaining > 10'sd0;
  wire xfer_end = fetching && remaining <= 10'sd4;
  wire sel_wr   = wr_req && req_addr == 2'd0;
  wire cmd_wr   = wr_req && req_addr == 2'd1;
  wire cmd_norm = cmd_wr && !cmd_q[31];
  wire stop_hit = cmd_norm && req_wdata[27:25] == 3'd4 && cmd_q[27:25] != 3'd0;
  wire reinit   = sel_wr || xfer_end || stop_hit;
  wire [2:0] pin = req_wdata[2:0];

  assign bus_phase = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0; cmd_q <= '0; data_q <= '0; stat_q <= '0;
      phase_q <= PH_IDLE; ptr_q <= '0; total_q <= '0; cyc_q <= '0;
      tgt_sel <= 1'b0; avail <= 1'b0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) begin
        case (req_addr)
          2'd0: rsp_rdata <= sel_q;
          2'd1: rsp_rdata <= cmd_q;
          2'd2: begin
            rsp_rdata <= {26'd0, stat_q};
            stat_q[ST_USE] <= 1'b1;
          end
          default: begin
            if (fetching) begin
              data_q <= data_next;
              rsp_rdata <= data_next;
              ptr_q <= ptr_q + 8'($countones(lane_ok));
              if (xfer_end)
                phase_q <= (cyc_q == 3'd5 || cyc_q == 3'd7) ? PH_IDLE : PH_WAIT;
            end else begin
              rsp_rdata <= data_q;
            end
          end
        endcase
      end
      if (wr_req) begin
        case (req_addr)
          2'd0: begin
            sel_q <= req_wdata;
            if (pin != 3'd0) begin
              stat_q[ST_ACT] <= 1'b0;
              stat_q[ST_RDY] <= 1'b1;
              stat_q[ST_WAIT] <= 1'b1;
              phase_q <= PH_IDLE;
              stat_q[ST_ERR] <= !mon_present[pin];
            end
          end
          2'd1: begin
            if (cmd_q[31]) begin
              if (!req_wdata[31]) begin
                cmd_q[31] <= 1'b0;
                stat_q <= '0;
                stat_q[ST_RDY] <= 1'b1;
                stat_q[ST_ERR] <= !avail;
                phase_q <= PH_IDLE;
              end
            end else begin
              if (req_wdata[31]) begin
                stat_q[ST_INT] <= 1'b0;
                stat_q[ST_RDY] <= 1'b1;
              end
              cmd_q <= {req_wdata[31], 1'b0, req_wdata[29:0]};
              total_q <= req_wdata[24:16];
              if (req_wdata[7:1] == TARGET) tgt_sel <= 1'b1;
              if (req_wdata[26]) ptr_q <= req_wdata[15:8];
              cyc_q <= req_wdata[27:25];
              if (stop_hit) begin
                phase_q <= PH_IDLE;
                stat_q[ST_ACT] <= 1'b0;
              end else if (req_wdata[25]) begin
                phase_q <= PH_DATA;
                stat_q[ST_ACT] <= 1'b1;
              end
            end
          end
          2'd2: if (req_wdata[ST_USE]) stat_q[ST_USE] <= 1'b0;
          default: ;
        endcase
      end
      if (reinit) begin
        tgt_sel <= 1'b0;
        avail <= sel_wr && pin != 3'd0 && mon_present[pin];
        ptr_q <= '0;
        total_q <= '0;
        cyc_q <= '0;
      end
    end
  end
endmodule

module edid_read_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [5:0]  stat_q,
  input logic [1:0]  phase_q,
  input logic [31:0] cmd_q
);
  assert_rsp_follows_read_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_rsp_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  assert_status_read_sets_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 2'd2) |=> stat_q[5]);
  assert_status_w1c_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd2 && req_wdata[5]) |=> !stat_q[5]);
  assert_select_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd0 && req_wdata[2:0] != 3'd0)
      |=> (phase_q == 2'd0 && stat_q[0] && stat_q[2] && !stat_q[1]));
  assert_clear_int_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd1 && cmd_q[31] && !req_wdata[31])
      |=> (stat_q[0] && stat_q[2:1] == 2'b00 && stat_q[5:4] == 2'b00 && phase_q == 2'd0 && !cmd_q[31]));
  assert_swrdy_stripped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd1 && !cmd_q[31]) |=> !cmd_q[30]);
  assert_data_cycle_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 2'd1 && !cmd_q[31] && req_wdata[25])
      |=> (phase_q == 2'd1 && stat_q[1]));
endmodule

bind edid_read_ctrl edid_read_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .stat_q(stat_q), .phase_q(phase_q), .cmd_q(cmd_q)
);

// File: tb/edid_read_ctrl_tb.sv
module edid_read_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0] mon_present = 8'b0000_0010;
  logic ld_en = 1'b0;
  logic [6:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [1:0] bus_phase;

  int n_run = 0, n_fail = 0;
  logic [31:0] shadow = '0;
  bit done = 0;

  always #2 clk = ~clk;

  edid_read_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mon_present(mon_present), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .bus_phase(bus_phase)
  );

  function automatic logic [7:0] eb(input int i);
    return 8'((i * 7 + 3) ^ 8'h5A);
  endfunction

  function automatic logic [31:0] cmd(input int cyc, input int cnt, input int idx, input int addr8);
    return (32'(cyc) << 25) | (32'(cnt) << 16) | (32'(idx) << 8) | 32'(addr8);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic chk_status(input logic [31:0] exp, input string tag);
    logic [31:0] d; logic v;
    wr(2'd2, 32'h20);
    rd(2'd2, d, v);
    check(d == exp, tag, d, exp);
  endtask

  task automatic chk_data(input logic [31:0] exp, input string tag);
    logic [31:0] d; logic v;
    rd(2'd3, d, v);
    check(d == exp, tag, d, exp);
    shadow = exp;
  endtask

  task automatic chk_phase(input logic [1:0] exp, input string tag);
    check(bus_phase == exp, tag, 32'(bus_phase), 32'(exp));
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    check(rsp_valid == 1'b0, "R1 rsp_valid idle", 32'(rsp_valid), 0);
    chk_phase(2'd0, "R1 phase after reset");
    rd(2'd2, d, v);
    check(d == 32'h0, "R1 status after reset", d, 0);
    check(v == 1'b1, "R14 rsp_valid after read", 32'(v), 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R14 rsp_valid drops", 32'(rsp_valid), 0);
    rd(2'd0, d, v);
    check(d == 32'h0, "R1 select after reset", d, 0);
  endtask

  task automatic t_status;
    logic [31:0] d; logic v;
    wr(2'd0, 32'h1);
    chk_phase(2'd0, "R2 phase idle after select");
    chk_status(32'h05, "R2 status present pin");
    rd(2'd2, d, v);
    check(d == 32'h25, "R3 in-use set by read", d, 32'h25);
    wr(2'd2, 32'h0000_001F);
    rd(2'd2, d, v);
    check(d == 32'h25, "R3 write without bit5 keeps status", d, 32'h25);
    wr(2'd0, 32'h2);
    chk_status(32'h0D, "R2 status absent pin error");
  endtask

  task automatic t_full_read;
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(5, 6, 0, 8'hA1));
    chk_phase(2'd1, "R9 data phase");
    chk_status(32'h07, "R9 active set");
    chk_data({eb(3), eb(2), eb(1), eb(0)}, "R5 four bytes packed");
    chk_data({eb(3), eb(2), eb(5), eb(4)}, "R5 partial keeps upper");
    chk_phase(2'd0, "R6 stop-ended goes idle");
    chk_data(shadow, "R6 reinit then unchanged");
  endtask

  task automatic t_index_wait;
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(3, 18, 16, 8'hA1));
    chk_data({shadow[31:16], eb(17), eb(16)}, "R7 index loads pointer");
    chk_phase(2'd2, "R6 wait-ended goes wait");
  endtask

  task automatic t_wrong_addr;
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(1, 4, 0, 8'hA3));
    chk_data(32'h0, "R4 other target yields zeros");
  endtask

  task automatic t_unavailable;
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(1, 4, 0, 8'hA1));
    chk_data({eb(3), eb(2), eb(1), eb(0)}, "R4 target 0x50 fetches");
    wr(2'd0, 32'h2);
    wr(2'd1, cmd(5, 2, 0, 8'hA1));
    chk_data({shadow[31:16], 16'h0}, "R12 no monitor zeros");
  endtask

  task automatic t_edge;
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(3, 132, 126, 8'hA1));
    chk_data({16'h0, eb(127), eb(126)}, "R12 bytes past end are zero");
    chk_data(32'h0, "R12 pointer held at end");
    chk_phase(2'd2, "R6 wait after edge transfer");
  endtask

  task automatic t_stop;
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(0, 4, 0, 8'hA1));
    wr(2'd1, cmd(4, 4, 0, 8'hA1));
    chk_phase(2'd0, "R8 stop ignored after no-cycle");
    chk_data({eb(3), eb(2), eb(1), eb(0)}, "R8 state kept after ignored stop");
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(1, 8, 0, 8'hA1));
    wr(2'd1, cmd(4, 8, 0, 8'hA1));
    chk_phase(2'd0, "R8 stop goes idle");
    chk_status(32'h05, "R8 stop clears active");
    chk_data(shadow, "R8 stop reinitialises");
  endtask

  task automatic t_clear_int;
    logic [31:0] d; logic v;
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h8000_0000);
    rd(2'd1, d, v);
    check(d == 32'h8000_0000, "R10 clear bit stored", d, 32'h8000_0000);
    wr(2'd1, 32'h0000_00A1);
    rd(2'd1, d, v);
    check(d == 32'h0, "R10 falling edge clears only bit31", d, 0);
    rd(2'd2, d, v);
    check(d == 32'h01, "R10 reset status ready", d, 32'h01);
    chk_phase(2'd0, "R10 reset phase idle");
    wr(2'd0, 32'h2);
    wr(2'd1, 32'h8000_0000);
    wr(2'd1, 32'h0);
    rd(2'd2, d, v);
    check(d == 32'h09, "R10 reset status with error", d, 32'h09);
  endtask

  task automatic t_swrdy;
    logic [31:0] d; logic v;
    wr(2'd1, 32'h4000_00A1);
    rd(2'd1, d, v);
    check(d == 32'h0000_00A1, "R11 bit30 stripped", d, 32'h0000_00A1);
  endtask

  task automatic t_misc;
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(1, 4, 0, 8'hA0));
    chk_data(shadow, "R13 write-direction read unchanged");
    wr(2'd0, 32'h1);
    wr(2'd1, cmd(2, 4, 0, 8'hA1));
    chk_phase(2'd0, "R9 reserved code keeps phase");
    chk_status(32'h05, "R9 reserved code keeps active");
    wr(2'd1, cmd(1, 4, 0, 8'hA1));
    wr(2'd0, 32'h0);
    chk_status(32'h07, "R2 pin 0 keeps status");
    chk_phase(2'd1, "R2 pin 0 keeps phase");
    chk_data(shadow, "R13 remaining zero read unchanged");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 7'(i); ld_data = eb(i);
    end
    @(negedge clk);
    ld_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_status;
    t_full_read;
    t_index_wait;
    t_wrong_addr;
    t_unavailable;
    t_edge;
    t_stop;
    t_clear_int;
    t_swrdy;
    t_misc;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule